// File: doc/BRIEF.md
# Multi-Mode Test Register

This block is a parameterised n-bit register whose flops serve in one of four roles. A two-bit mode input selects the role, and the choice takes effect at the next clock edge. In its functional role the register loads a parallel word on every clock. In its scan role it forms a serial shift path from a scan-in pin to a scan-out pin. In its generator role it steps through a linear feedback shift sequence on its own and produces stimulus for a circuit under test. In its compaction role it folds one parallel response word per clock into a running signature.

A test sequencer outside the block picks a mode for each session. The same instance can therefore drive patterns into one circuit in one session and compact the responses of another circuit in a later session. Typical use is to seed the register with a parallel load or a scan shift, run the generator or the compactor for a number of cycles, then shift the signature out serially. Comparing that signature against an expected value is done outside the block.

The feedback taps are a parameter. The default of 8'hB8 gives a maximal-length sequence for the default width of 8.

Top module: `multimode_test_register`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage is cleared to zero at that edge (synchronous reset).
- R2: With `mode` = 2'b00 (scan), each stage takes the value of the stage below it, stage 0 takes `scan_in`, and `par_in` has no effect.
- R3: `scan_out` always equals the top stage (bit WIDTH-1) of the register, in every mode.
- R4: With `mode` = 2'b01 (generator), the register shifts toward the top bit. Stage 0 takes the XOR of the current stages selected by the set bits of `TAPS`. Neither `par_in` nor `scan_in` has any effect.
- R5: With the default parameters (WIDTH 8, TAPS 8'hB8), generator mode started from a non-zero seed returns to that seed after exactly 255 steps and not before.
- R6: In generator mode the all-zero state stays all-zero, and a non-zero state never steps to all-zero.
- R7: With `mode` = 2'b10 (functional), the register loads `par_in` on every clock.
- R8: With `mode` = 2'b11 (compaction), the next state is the generator step of R4 XORed bit by bit with `par_in`. For example, from 8'h3C with `par_in` 8'h0F the next state is 8'h76.
- R9: Shifting WIDTH zeros in through scan mode leaves the register all-zero, whatever its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Role select: 00 scan, 01 generator, 10 functional, 11 compaction |
| par_in | input | WIDTH | Parallel data or response word |
| scan_in | input | 1 | Serial input to stage 0 in scan mode |
| par_out | output | WIDTH | Current register contents |
| scan_out | output | 1 | Top stage of the register |

## Verification
The bench drives scan and generator steps with random parallel data applied. A design that let `par_in` leak into either mode would then produce states that differ from the model. A full 255-step generator run from seed 8'h01 catches wrong tap positions or a wrong shift direction: either fault shortens the period or breaks the sequence. Directed steps from the all-zero state and a hard-coded compaction result target two failure modes. The first is a generator that escapes lock-up or falls into it. The second is a compactor that swaps the order of the XOR terms or drops them. Random mode changes with random data check every state and `scan_out` after each edge, so an off-by-one in the serial chain or a swapped mode encoding shows up within a few cycles.

// File: rtl/mtr_pkg.sv
// Package: shared mode encoding for the multi-mode test register.
// Assumes a two-bit mode bus driven by an external test sequencer.
package mtr_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_LOAD = 2'b10,
        MODE_SIG  = 2'b11
    } mtr_mode_e;

endpackage

// File: rtl/mtr_feedback.sv
// Module: parity of the register stages selected by a tap mask.
// Assumes TAPS has its top bit set so the polynomial has full degree.
module mtr_feedback #(
    parameter int unsigned      WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);

    logic [WIDTH-1:0] tapped;

    // Select the tapped stages and reduce them to one parity bit.
    always_comb begin
        tapped = state & TAPS;
        fb     = ^tapped;
    end

endmodule

// File: rtl/mtr_cell.sv
// Module: next-value logic for one stage of the register.
// Assumes ser_src is the serial source already chosen for this stage
// (the lower neighbour, or scan-in / feedback for stage 0).
module mtr_cell
    import mtr_pkg::*;
(
    input  mtr_mode_e mode,
    input  logic      ser_src,
    input  logic      par_bit,
    output logic      nxt
);

    // Pick the stage's next value according to the active role.
    always_comb begin
        unique case (mode)
            MODE_SCAN: nxt = ser_src;
            MODE_GEN:  nxt = ser_src;
            MODE_LOAD: nxt = par_bit;
            MODE_SIG:  nxt = ser_src ^ par_bit;
            default:   nxt = ser_src;
        endcase
    end

endmodule

// File: rtl/multimode_test_register.sv
// Module: n-bit register with scan, pattern generator, functional and
// signature compaction roles chosen by a two-bit mode input.
// Assumes: synchronous active-low reset; generator mode seeded non-zero
// by the user; TAPS describes a primitive polynomial for WIDTH.
module multimode_test_register
    import mtr_pkg::*;
#(
    parameter int unsigned      WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);

    localparam int unsigned TOP = WIDTH - 1;

    mtr_mode_e        mode_e;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_nxt;
    logic [WIDTH-1:0] ser;
    logic             fb;

    // Cast the raw mode bits to the shared enum.
    always_comb mode_e = mtr_mode_e'(mode);

    mtr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .state (q),
        .fb    (fb)
    );

    // Serial source for stage 0: scan-in while scanning, feedback otherwise.
    always_comb ser[0] = (mode_e == MODE_SCAN) ? scan_in : fb;

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_chain
            // Upper stages take their lower neighbour as serial source.
            always_comb ser[i] = q[i-1];
        end
        for (i = 0; i < WIDTH; i++) begin : g_cell
            mtr_cell u_cell (
                .mode    (mode_e),
                .ser_src (ser[i]),
                .par_bit (par_in[i]),
                .nxt     (q_nxt[i])
            );
        end
    endgenerate

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // Drive the outputs straight from the stages.
    always_comb begin
        par_out  = q;
        scan_out = q[TOP];
    end

    a_r1_sync_clear: assert property (@(posedge clk)
        !rst_n |=> (par_out == '0));

    a_r2_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (par_out == {$past(par_out[TOP-1:0]), $past(scan_in)}));

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out == $past(par_in)));

    a_r6_no_escape: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && par_out == '0) |=> (par_out == '0));

    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && par_out != '0) |=> (par_out != '0));

    a_r3_scan_out_top: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (scan_out == $past(par_out[TOP-1])));

endmodule

// File: tb/tb_multimode_test_register.sv
module tb_multimode_test_register;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] TP = 8'hB8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b10;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_out;
    logic         scan_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [W-1:0] exp_q = '0;

    multimode_test_register #(.WIDTH(W), .TAPS(TP)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
        .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected next state from the requirements (R2, R4, R7, R8).
    function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] s,
                                           input logic [W-1:0] d, input logic si);
        logic f;
        f = ^(s & TP);
        case (m)
            2'b00:   return {s[W-2:0], si};
            2'b01:   return {s[W-2:0], f};
            2'b10:   return d;
            default: return {s[W-2:0], f} ^ d;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one cycle at the falling edge, check at the next falling edge.
    task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic si,
                        input logic rn, input string tag);
        mode = m; par_in = d; scan_in = si; rst_n = rn;
        @(posedge clk);
        exp_q = rn ? model(m, exp_q, d, si) : '0;
        @(negedge clk);
        check(tag, par_out, exp_q);
        check("R3 scan_out", {7'b0, scan_out}, {7'b0, exp_q[W-1]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] seed_q;
        int period;
        void'($urandom(32'd2718));
        @(negedge clk);
        // R1: reset clears the register
        step(2'b10, 8'hFF, 1'b1, 1'b1, "R7 load");
        step(2'b10, 8'h5A, 1'b1, 1'b0, "R1 reset");
        check("R1 reset zero", par_out, 8'h00);
        // R6: zero state locks in generator mode
        for (int k = 0; k < 5; k++) step(2'b01, 8'hFF, 1'b1, 1'b1, "R6 zero lock");
        check("R6 still zero", par_out, 8'h00);
        // R8: directed compaction value
        step(2'b10, 8'h3C, 1'b0, 1'b1, "R7 load");
        step(2'b11, 8'h0F, 1'b0, 1'b1, "R8 compact");
        check("R8 hard value", par_out, 8'h76);
        // R9: clear by shifting zeros
        step(2'b10, 8'hA5, 1'b0, 1'b1, "R7 load");
        for (int k = 0; k < W; k++) step(2'b00, 8'hFF, 1'b0, 1'b1, "R2 scan");
        check("R9 scan clear", par_out, 8'h00);
        // R5: maximal period from seed 01
        step(2'b10, 8'h01, 1'b0, 1'b1, "R7 load");
        seed_q = par_out;
        period = 0;
        for (int k = 0; k < 300; k++) begin
            step(2'b01, W'($urandom), 1'($urandom), 1'b1, "R4 gen");
            if (par_out == '0) check("R6 nonzero", par_out, 8'h01);
            if (par_out == seed_q) begin
                period = k + 1;
                break;
            end
        end
        total++;
        if (period != 255) begin
            bad++;
            $display("FAIL R5 period: actual=%0d expected=255", period);
        end
        // Random mix of all modes with random data
        for (int k = 0; k < 600; k++) begin
            logic [1:0] m;
            m = 2'($urandom);
            step(m, W'($urandom), 1'($urandom), ($urandom % 50) != 0,
                 m == 2'b00 ? "R2 scan" : m == 2'b01 ? "R4 gen" :
                 m == 2'b10 ? "R7 load" : "R8 compact");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule